// File: doc/BRIEF.md
# PLL Divider Control Register Bank

This block holds the three divider control words of a clock synthesizer: the reference (input) divider, the feedback divider and the post (output) divider. Software writes each word over a simple 32-bit write bus. Every write carries a hold flag. A write with the hold flag set only stages its word in a shadow copy. A write with the hold flag clear stages its word and then moves all three shadow copies into the active registers on the same clock edge. A batch of divider changes therefore reaches the synthesizer as one step.

The active words are decoded into ratios and driven to downstream logic. The ratio of a word is one when its bypass field is set. Otherwise it is the sum of the high and low counts. A status word gives a lock flag and a configuration-error flag. Each commit drops lock at once and restores it after a fixed, parameterised number of reference cycles, which stands in for the relock time of the analog loop. Software polls the status word after a commit. The new configuration has failed if lock is still low after the allowed wait, or if the error flag is set.

Top module: `pll_div_bank`

## Requirements
- R1: After reset all three active and shadow words equal 0x2000 (bypass only), so every ratio output is 1. The status word reads 1 (locked, no error).
- R2: Address bits [3:2] select the word: 0 selects the input divider, 1 the feedback divider and 2 the output divider, so the byte offsets are 0x0, 0x4 and 0x8. A write to word index 3 (offset 0xC) changes nothing, and a read of it returns zero.
- R3: Field positions within a word: bits 5:0 hold the low count, 11:6 the high count, 12 the odd-edge flag (stored only), 13 bypass and 14 hold.
- R4: A write with bit 14 set updates only the shadow copy. The ratio outputs, the readback and the lock state do not change.
- R5: A write with bit 14 clear copies all three shadow words (including the word just written) into the active registers. The ratio outputs show the new values one cycle after the write.
- R6: Each ratio output equals 1 when bit 13 of its active word is set, and high count plus low count otherwise (range 0 to 126).
- R7: A read of a divider address returns the active word in bits 14:0, not the shadow word. Bits 31:15 read as zero, whatever was written to them.
- R8: The commit edge clears lock. Lock sets again exactly LOCK_CYCLES clock edges after the commit edge. A new commit while lock is low restarts the count.
- R9: A commit sets the error flag if any committed word has bypass clear and a ratio of zero, and clears it otherwise. The flag changes only on a commit.
- R10: The status word carries lock in bit 0 and error in bit 1. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| div_wr | input | 1 | Write strobe for the divider words |
| div_addr | input | ADDR_W | Byte address of the divider word |
| div_wdata | input | 32 | Write data |
| div_rdata | output | 32 | Active word at div_addr (combinational) |
| stat_rdata | output | 32 | Status word: bit 0 lock, bit 1 error |
| ratio_in | output | 7 | Decoded input divider ratio |
| ratio_fb | output | 7 | Decoded feedback divider ratio |
| ratio_out | output | 7 | Decoded output divider ratio |

## Verification
Each of the three word positions is swept over every mix of bypass, high count 0 to 3 and low count 0 to 3. Each value is first staged with the hold flag set and then committed. The staged step shows that shadow and active storage are kept apart, and the commit step covers the ratio sum, the bypass override and the zero-ratio error case. A separate staged input/feedback/output sequence, which includes the largest counts, shows that the three ratios change together on a single edge. Further cases cover the unused offset, the ones written into the upper pad bits, and a second commit made while the relock count is still running. These show the address decode, the readback masking and the restart of the lock timer.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;

    localparam int BUS_W   = 32;
    localparam int CNT_FW  = 6;
    localparam int RATIO_W = CNT_FW + 1;
    localparam int NUM_DIV = 3;
    localparam int KEEP_W  = 3 + 2 * CNT_FW;

    typedef struct packed {
        logic              hold;
        logic              bypass;
        logic              odd_edge;
        logic [CNT_FW-1:0] high;
        logic [CNT_FW-1:0] low;
    } div_word_t;

    localparam div_word_t DIV_RESET = '{hold: 1'b0, bypass: 1'b1, odd_edge: 1'b0,
                                        high: '0, low: '0};

    function automatic logic [RATIO_W-1:0] div_ratio(input div_word_t w);
        if (w.bypass)
            return RATIO_W'(1);
        return RATIO_W'(w.high) + RATIO_W'(w.low);
    endfunction

    function automatic logic div_bad(input div_word_t w);
        return !w.bypass && (w.high == '0) && (w.low == '0);
    endfunction

endpackage

// File: rtl/div_slot.sv
module div_slot
    import pll_div_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      ld,
    input  div_word_t wword,
    input  logic      commit,
    output div_word_t staged,
    output div_word_t active
);

    div_word_t shadow_q;
    div_word_t active_q;

    assign staged = ld ? wword : shadow_q;
    assign active = active_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= DIV_RESET;
            active_q <= DIV_RESET;
        end else begin
            shadow_q <= staged;
            if (commit)
                active_q <= staged;
        end
    end

    // R4: the active word moves only on a commit edge
    p_active_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(active));

    // R5: a commit edge leaves the active copy equal to the shadow copy
    p_commit_match_r5: assert property (@(posedge clk) disable iff (rst)
        commit |=> (active_q == shadow_q));

endmodule

// File: rtl/lock_seq.sv
module lock_seq #(
    parameter int LOCK_CYCLES = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic commit,
    input  logic cfg_bad,
    output logic lock,
    output logic err
);

    localparam int CNT_W = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock <= 1'b1;
            err  <= 1'b0;
            cnt  <= '0;
        end else if (commit) begin
            lock <= 1'b0;
            err  <= cfg_bad;
            cnt  <= CNT_W'(LOCK_CYCLES - 1);
        end else if (!lock) begin
            if (cnt == '0)
                lock <= 1'b1;
            else
                cnt <= cnt - 1'b1;
        end
    end

    p_lock_drop_r8: assert property (@(posedge clk) disable iff (rst)
        commit |=> !lock);

    p_lock_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (!commit && lock) |=> lock);

    p_err_only_commit_r9: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(err));

    p_err_follows_cfg_r9: assert property (@(posedge clk) disable iff (rst)
        commit |=> (err == $past(cfg_bad)));

endmodule

// File: rtl/pll_div_bank.sv
module pll_div_bank
    import pll_div_pkg::*;
#(
    parameter int LOCK_CYCLES = 16,
    parameter int ADDR_W      = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               div_wr,
    input  logic [ADDR_W-1:0]  div_addr,
    input  logic [BUS_W-1:0]   div_wdata,
    output logic [BUS_W-1:0]   div_rdata,
    output logic [BUS_W-1:0]   stat_rdata,
    output logic [RATIO_W-1:0] ratio_in,
    output logic [RATIO_W-1:0] ratio_fb,
    output logic [RATIO_W-1:0] ratio_out
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0] word_idx;
    logic             hit;
    logic             commit;
    logic             cfg_bad;
    logic             lock;
    logic             err;
    div_word_t        wword;
    div_word_t        staged [NUM_DIV];
    div_word_t        active [NUM_DIV];
    logic [NUM_DIV-1:0] bad_vec;
    logic             unused_bits;

    assign word_idx    = div_addr[ADDR_W-1:2];
    assign hit         = word_idx < IDX_W'(NUM_DIV);
    assign wword       = div_word_t'(div_wdata[KEEP_W-1:0]);
    assign commit      = div_wr && hit && !wword.hold;
    assign unused_bits = ^{div_wdata[BUS_W-1:KEEP_W], div_addr[1:0]};

    generate
        for (genvar g = 0; g < NUM_DIV; g++) begin : g_slot
            div_slot u_slot (
                .clk    (clk),
                .rst    (rst),
                .ld     (div_wr && hit && (word_idx == IDX_W'(g))),
                .wword  (wword),
                .commit (commit),
                .staged (staged[g]),
                .active (active[g])
            );
            assign bad_vec[g] = div_bad(staged[g]);
        end
    endgenerate

    assign cfg_bad = |bad_vec;

    lock_seq #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
        .clk     (clk),
        .rst     (rst),
        .commit  (commit),
        .cfg_bad (cfg_bad),
        .lock    (lock),
        .err     (err)
    );

    always_comb begin
        div_rdata = '0;
        for (int i = 0; i < NUM_DIV; i++)
            if (word_idx == IDX_W'(i))
                div_rdata = {{(BUS_W-KEEP_W){1'b0}}, active[i]};
    end

    assign stat_rdata = {{(BUS_W-2){1'b0}}, err, lock};
    assign ratio_in   = div_ratio(active[0]);
    assign ratio_fb   = div_ratio(active[1]);
    assign ratio_out  = div_ratio(active[2]);

    // R2: a write outside the three words leaves every ratio untouched
    p_bad_addr_ignored_r2: assert property (@(posedge clk) disable iff (rst)
        (div_wr && !hit) |=> ($stable(ratio_in) && $stable(ratio_fb) && $stable(ratio_out)));

    // R6: ratio is never zero while its word is bypassed
    p_bypass_nonzero_r6: assert property (@(posedge clk) disable iff (rst)
        active[1].bypass |-> (ratio_fb != '0));

endmodule

// File: tb/sim_pll_div_bank.sv
module sim_pll_div_bank;

    localparam int CLK_PERIOD = 10;
    localparam int L          = 5;

    logic        clk   = 1'b0;
    logic        rst   = 1'b1;
    logic        wr    = 1'b0;
    logic [3:0]  addr  = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [31:0] stat;
    logic [6:0]  r_in, r_fb, r_out;

    int n_chk  = 0;
    int n_fail = 0;

    logic [14:0] sh  [3];
    logic [14:0] act [3];
    logic        e_err;

    always #(CLK_PERIOD/2) clk = ~clk;

    pll_div_bank #(.LOCK_CYCLES(L), .ADDR_W(4)) u0 (
        .clk(clk), .rst(rst), .div_wr(wr), .div_addr(addr), .div_wdata(wdata),
        .div_rdata(rdata), .stat_rdata(stat),
        .ratio_in(r_in), .ratio_fb(r_fb), .ratio_out(r_out)
    );

    function automatic int rat(input logic [14:0] w);
        if (w[13]) return 1;
        return int'(w[11:6]) + int'(w[5:0]);
    endfunction

    function automatic logic [31:0] mk(input bit hold, input bit bp, input bit edg,
                                       input int hi, input int lo);
        logic [5:0] h6 = 6'(hi);
        logic [5:0] l6 = 6'(lo);
        return {17'b0, hold, bp, edg, h6, l6};
    endfunction

    task automatic chk(input string tag, input longint a, input longint e);
        n_chk++;
        if (a != e) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, a, e);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic check_all(input string tag, input bit exp_lock);
        logic [31:0] d;
        chk({tag, " R6 ratio_in"},  r_in,  rat(act[0]));
        chk({tag, " R6 ratio_fb"},  r_fb,  rat(act[1]));
        chk({tag, " R6 ratio_out"}, r_out, rat(act[2]));
        for (int i = 0; i < 3; i++) begin
            rd(4'(i * 4), d);
            chk($sformatf("%s R7 readback %0d", tag, i), d, {17'b0, act[i]});
        end
        chk({tag, " R10 status"}, stat, {30'b0, e_err, exp_lock});
    endtask

    task automatic wr_word(input logic [3:0] a, input logic [31:0] d);
        int idx;
        @(negedge clk);
        addr = a; wdata = d; wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr = 1'b0;
        idx = int'(a[3:2]);
        if (idx < 3) begin
            sh[idx] = d[14:0];
            if (!d[14]) begin
                e_err = 1'b0;
                for (int i = 0; i < 3; i++) begin
                    act[i] = sh[i];
                    if (!sh[i][13] && sh[i][11:0] == 12'd0) e_err = 1'b1;
                end
            end
        end
    endtask

    task automatic wait_lock(input string tag);
        chk({tag, " R8 lock drop"}, stat[0], 0);
        for (int i = 1; i < L; i++) begin
            @(posedge clk); @(negedge clk);
            chk({tag, " R8 lock low"}, stat[0], 0);
        end
        @(posedge clk); @(negedge clk);
        chk({tag, " R8 lock back"}, stat[0], 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int i = 0; i < 3; i++) begin
            sh[i] = 15'h2000; act[i] = 15'h2000;
        end
        e_err = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check_all("R1 reset", 1'b1);

        // Sweep every word position over bypass, high 0..3, low 0..3 (R4 R5 R6 R9)
        for (int r = 0; r < 3; r++)
            for (int bp = 0; bp < 2; bp++)
                for (int hi = 0; hi < 4; hi++)
                    for (int lo = 0; lo < 4; lo++) begin
                        wr_word(4'(r * 4), mk(1'b1, bp[0], lo[0], hi, lo));
                        check_all("R4 staged", 1'b1);
                        wr_word(4'(r * 4), mk(1'b0, bp[0], lo[0], hi, lo));
                        check_all("R5 R9 commit", 1'b0);
                        wait_lock("sweep");
                    end

        // R3 field positions and normal order: input, feedback staged, output commits
        wr_word(4'h0, mk(1'b1, 1'b0, 1'b1, 2, 1));
        wr_word(4'h4, mk(1'b1, 1'b0, 1'b0, 63, 63));
        check_all("R3 R4 two staged", 1'b1);
        chk("R3 feedback unchanged", r_fb, 1);
        wr_word(4'h8, mk(1'b0, 1'b0, 1'b0, 5, 7));
        chk("R3 R5 ratio_in", r_in, 3);
        chk("R3 R5 ratio_fb", r_fb, 126);
        chk("R3 R5 ratio_out", r_out, 12);
        check_all("R5 batch", 1'b0);
        wait_lock("batch");

        // R2 unused offset is ignored and reads zero
        wr_word(4'hC, mk(1'b0, 1'b0, 1'b0, 0, 0));
        check_all("R2 offset C", 1'b1);
        rd(4'hC, d);
        chk("R2 offset C read", d, 0);

        // R9 error then cleared by a valid commit
        wr_word(4'h4, mk(1'b0, 1'b0, 1'b0, 0, 0));
        chk("R9 err set", stat[1], 1);
        wait_lock("err");
        chk("R9 err kept", stat[1], 1);
        wr_word(4'h4, mk(1'b0, 1'b0, 1'b0, 4, 4));
        chk("R9 err cleared", stat[1], 0);
        chk("R9 ratio_fb", r_fb, 8);
        wait_lock("err clear");

        // R7 pad bits written as ones read back as zero
        wr_word(4'h0, 32'hFFFF_8000 | mk(1'b0, 1'b0, 1'b0, 9, 3));
        rd(4'h0, d);
        chk("R7 pad zero", d, {17'b0, 15'(mk(1'b0, 1'b0, 1'b0, 9, 3))});
        check_all("R7 pad", 1'b0);
        wait_lock("pad");

        // R8 commit during relock restarts the count
        wr_word(4'h8, mk(1'b0, 1'b0, 1'b0, 1, 1));
        @(posedge clk); @(negedge clk);
        chk("R8 still low", stat[0], 0);
        wr_word(4'h8, mk(1'b0, 1'b0, 1'b0, 2, 1));
        check_all("R8 restart", 1'b0);
        wait_lock("restart");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule